// File: doc/BRIEF.md
# Timed Wash Cycle Sequencer

This block sequences one complete wash program for a basic washing machine. A three-bit step register moves through a fixed order: idle, first fill, wash, first drain, second fill, rinse, final drain, and back to idle. A duration counter inside the block times each step. When the counter reaches the terminal count for the current step, it raises a done flag. That flag moves the step register forward and clears the counter on the same clock edge.

The block drives three actuator lines: the water inlet valve, low-speed drum drive and high-speed drum drive. It also brings out the counter-clear strobe, which is the done flag itself, so the strobe is a Mealy output of the current step and count. A power input starts a program. Dropping power at any point sends the machine back to idle. One program runs for each rising start: after the final drain the machine waits in idle until power goes low and then high again. Four parameters set the step durations in clock cycles. Water temperature, motor power stages and door safety are handled outside this block.

Top module: `wash_seq_top`

## Requirements
- R1: Synchronous active-high `rst` puts `step_code` at 0 (idle) and drives all four outputs low. A reset in the middle of a program aborts it.
- R2: In idle with `power_en` high, the block enters step code 1 (first fill) on the next clock. This applies after reset, and also after `power_en` has been low for at least one cycle.
- R3: The step codes follow the order 0 → 1 (fill) → 2 (wash) → 3 (drain) → 4 (fill) → 5 (rinse) → 6 (drain) → 0.
- R4: Steps 1 and 4 each last `FILL_CYC` cycles, step 2 lasts `WASH_CYC`, steps 3 and 6 last `DRAIN_CYC`, and step 5 lasts `RINSE_CYC`. The step code holds between advances.
- R5: `fill_valve` is high only in steps 1 and 4, `drum_slow` only in steps 2 and 5, and `drum_fast` only in steps 3 and 6. In idle all three are low.
- R6: `timer_clr` is high in exactly the last cycle of each active step, and the step advances on that clock edge. It is never high in idle.
- R7: `drum_slow` and `drum_fast` are never high together, and at most one of the three actuator lines is high at a time.
- R8: When `power_en` is low, the step returns to idle on the next clock. The counter is cleared, so a restart gives the first fill its full duration.
- R9: After step 6 completes, the block stays in idle while `power_en` stays high. It starts again only after `power_en` goes low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_en | input | 1 | Power/start level; high runs a program, low aborts it |
| fill_valve | output | 1 | Water inlet valve open |
| drum_slow | output | 1 | Low-speed drum drive (wash, rinse) |
| drum_fast | output | 1 | High-speed drum drive (drains) |
| timer_clr | output | 1 | Step done; the counter clears and the step advances on this edge |
| step_code | output | 3 | Current step code (0 idle … 6 final drain) |

## Verification
The assertions assume that `power_en` is synchronous to `clk` and changes only between edges. They also assume every duration parameter is at least one, so each active step produces a done pulse. The bench changes `power_en` and `rst` only on falling edges. It uses short but distinct durations, so an off-by-one in any step shows up as a shifted `timer_clr` or step code. The aborts by power loss and by reset are placed in the middle of a step, so a counter that was not cleared would shorten the next first fill.

// File: rtl/wash_seq_pkg.sv
package wash_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_FILL1  = 3'd1,
    ST_WASH   = 3'd2,
    ST_DRAIN1 = 3'd3,
    ST_FILL2  = 3'd4,
    ST_RINSE  = 3'd5,
    ST_DRAIN2 = 3'd6,
    ST_BAD    = 3'd7
  } step_e;

  typedef struct packed {
    logic valve;
    logic slow;
    logic fast;
    logic clr;
  } drive_t;

  function automatic logic step_active(step_e s);
    return (s != ST_OFF) && (s != ST_BAD);
  endfunction

endpackage

// File: rtl/wash_step_timer.sv
module wash_step_timer
  import wash_seq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int FILL_CYC  = 6,
  parameter int WASH_CYC  = 10,
  parameter int DRAIN_CYC = 5,
  parameter int RINSE_CYC = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  step_e step,
  input  logic  clr_i,
  output logic  done
);

  localparam logic [CNT_W-1:0] TERM_FILL  = CNT_W'(FILL_CYC - 1);
  localparam logic [CNT_W-1:0] TERM_WASH  = CNT_W'(WASH_CYC - 1);
  localparam logic [CNT_W-1:0] TERM_DRAIN = CNT_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] TERM_RINSE = CNT_W'(RINSE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             active;

  always_comb begin
    unique case (step)
      ST_FILL1, ST_FILL2:   term = TERM_FILL;
      ST_WASH:              term = TERM_WASH;
      ST_DRAIN1, ST_DRAIN2: term = TERM_DRAIN;
      ST_RINSE:             term = TERM_RINSE;
      default:              term = '0;
    endcase
  end

  assign active = step_active(step);
  assign done   = active && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active || !run || clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wash_step_fsm.sv
module wash_step_fsm
  import wash_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  power_en,
  input  logic  done,
  output step_e step
);

  step_e step_q;
  step_e step_d;
  logic  armed_q;

  always_comb begin
    step_d = step_q;
    if (!power_en) begin
      step_d = ST_OFF;
    end else begin
      case (step_q)
        ST_OFF:    if (armed_q) step_d = ST_FILL1;
        ST_FILL1:  if (done)    step_d = ST_WASH;
        ST_WASH:   if (done)    step_d = ST_DRAIN1;
        ST_DRAIN1: if (done)    step_d = ST_FILL2;
        ST_FILL2:  if (done)    step_d = ST_RINSE;
        ST_RINSE:  if (done)    step_d = ST_DRAIN2;
        ST_DRAIN2: if (done)    step_d = ST_OFF;
        default:                step_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_OFF;
      armed_q <= 1'b1;
    end else begin
      step_q <= step_d;
      if (!power_en) begin
        armed_q <= 1'b1;
      end else if (step_q == ST_OFF && armed_q) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign step = step_q;

endmodule

// File: rtl/wash_drive_dec.sv
module wash_drive_dec
  import wash_seq_pkg::*;
(
  input  step_e  step,
  input  logic   done,
  output drive_t drive
);

  always_comb begin
    drive = '0;
    case (step)
      ST_FILL1, ST_FILL2:   drive.valve = 1'b1;
      ST_WASH, ST_RINSE:    drive.slow  = 1'b1;
      ST_DRAIN1, ST_DRAIN2: drive.fast  = 1'b1;
      default:              drive       = '0;
    endcase
    drive.clr = done;
  end

endmodule

// File: rtl/wash_seq_top.sv
module wash_seq_top
  import wash_seq_pkg::*;
#(
  parameter int FILL_CYC  = 6,
  parameter int WASH_CYC  = 10,
  parameter int DRAIN_CYC = 5,
  parameter int RINSE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       power_en,
  output logic       fill_valve,
  output logic       drum_slow,
  output logic       drum_fast,
  output logic       timer_clr,
  output logic [2:0] step_code
);

  localparam int MAX_A   = (FILL_CYC > WASH_CYC) ? FILL_CYC : WASH_CYC;
  localparam int MAX_B   = (DRAIN_CYC > RINSE_CYC) ? DRAIN_CYC : RINSE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  step_e  step;
  logic   done;
  drive_t drive;

  wash_step_timer #(
    .CNT_W    (CNT_W),
    .FILL_CYC (FILL_CYC),
    .WASH_CYC (WASH_CYC),
    .DRAIN_CYC(DRAIN_CYC),
    .RINSE_CYC(RINSE_CYC)
  ) timer_i (
    .clk  (clk),
    .rst  (rst),
    .run  (power_en),
    .step (step),
    .clr_i(drive.clr),
    .done (done)
  );

  wash_step_fsm fsm_i (
    .clk     (clk),
    .rst     (rst),
    .power_en(power_en),
    .done    (done),
    .step    (step)
  );

  wash_drive_dec dec_i (
    .step (step),
    .done (done),
    .drive(drive)
  );

  assign fill_valve = drive.valve;
  assign drum_slow  = drive.slow;
  assign drum_fast  = drive.fast;
  assign timer_clr  = drive.clr;
  assign step_code  = step;

endmodule

// File: rtl/wash_seq_chk.sv
module wash_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       power_en,
  input logic       fill_valve,
  input logic       drum_slow,
  input logic       drum_fast,
  input logic       timer_clr,
  input logic [2:0] step_code
);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (step_code == 3'd0) |-> !(fill_valve || drum_slow || drum_fast || timer_clr));

  assert_one_drive_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({fill_valve, drum_slow, drum_fast}) <= 1);

  assert_no_dual_speed_R7: assert property (@(posedge clk) disable iff (rst)
    !(drum_slow && drum_fast));

  assert_power_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !power_en |=> (step_code == 3'd0));

  assert_advance_on_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (power_en && timer_clr) |=> (step_code != $past(step_code)));

  assert_hold_step_R4: assert property (@(posedge clk) disable iff (rst)
    (power_en && !timer_clr && step_code != 3'd0) |=> $stable(step_code));

  assert_wrap_to_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (power_en && timer_clr && step_code == 3'd6) |=> (step_code == 3'd0));

  assert_wash_after_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (power_en && timer_clr && step_code == 3'd1) |=> (step_code == 3'd2));

endmodule

bind wash_seq_top wash_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .power_en  (power_en),
  .fill_valve(fill_valve),
  .drum_slow (drum_slow),
  .drum_fast (drum_fast),
  .timer_clr (timer_clr),
  .step_code (step_code)
);

// File: tb/wash_seq_top_tb_top.sv
module wash_seq_top_tb_top;

  localparam int FILL  = 3;
  localparam int WASH  = 4;
  localparam int DRAIN = 2;
  localparam int RINSE = 3;

  // Step table: {code[2:0], duration[3:0], valve, slow, fast}
  localparam logic [9:0] PROGRAM [6] = '{
    {3'd1, 4'(FILL),  3'b100},
    {3'd2, 4'(WASH),  3'b010},
    {3'd3, 4'(DRAIN), 3'b001},
    {3'd4, 4'(FILL),  3'b100},
    {3'd5, 4'(RINSE), 3'b010},
    {3'd6, 4'(DRAIN), 3'b001}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       power_en = 1'b0;
  logic       fill_valve, drum_slow, drum_fast, timer_clr;
  logic [2:0] step_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  wash_seq_top #(
    .FILL_CYC (FILL),
    .WASH_CYC (WASH),
    .DRAIN_CYC(DRAIN),
    .RINSE_CYC(RINSE)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .power_en  (power_en),
    .fill_valve(fill_valve),
    .drum_slow (drum_slow),
    .drum_fast (drum_fast),
    .timer_clr (timer_clr),
    .step_code (step_code)
  );

  // Compares {code, valve, slow, fast, clr}
  task automatic check(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {step_code, fill_valve, drum_slow, drum_fast, timer_clr};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Walks cycles [first, dur) of one table step; sample before each step on negedge.
  task automatic run_step(int idx, int first, string req);
    logic [2:0] code;
    int         dur;
    logic [2:0] drv;
    code = PROGRAM[idx][9:7];
    dur  = int'(PROGRAM[idx][6:3]);
    drv  = PROGRAM[idx][2:0];
    for (int c = first; c < dur; c++) begin
      @(negedge clk);
      check(req, {code, drv, (c == dur - 1)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", 7'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 7'b0);

    // R2/R3/R4/R5/R6: full program from the table
    power_en = 1'b1;
    for (int s = 0; s < 6; s++) begin
      run_step(s, 0, "R3 R4 R5 R6 program step");
    end

    // R9: stays idle while power stays high
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 idle after final drain", 7'b0);
    end

    // R2/R9: low then high restarts
    power_en = 1'b0;
    @(negedge clk);
    check("R9 idle while low", 7'b0);
    power_en = 1'b1;
    run_step(0, 0, "R2 restart fill");
    run_step(1, 0, "R3 wash after restart");
    run_step(2, 0, "R3 drain after restart");

    // R8: power drop mid-step, then full first fill on return
    @(negedge clk);
    check("R8 fill2 first cycle", {3'd4, 3'b100, 1'b0});
    power_en = 1'b0;
    @(negedge clk);
    check("R8 abort to idle", 7'b0);
    power_en = 1'b1;
    run_step(0, 0, "R8 full fill after abort");
    @(negedge clk);
    check("R8 wash first cycle", {3'd2, 3'b010, 1'b0});
    @(negedge clk);
    check("R8 wash second cycle", {3'd2, 3'b010, 1'b0});

    // R1: reset mid-step, then restart with power held high
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-program", 7'b0);
    rst = 1'b0;
    run_step(0, 0, "R1 R2 start after reset");
    run_step(1, 0, "R4 wash after reset");

    done_run = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done_run && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule